// File: doc/BRIEF.md
# Outer-Product SIMD Lane Array

This block is a sixteen-lane fixed-point datapath that runs one operation per strobe, all lanes in lock-step. A host-side port fills an operand store (the even bank) with rows of lane vectors. A sequencer then issues operations. It can load a row into the per-lane operand register, accumulate a broadcast-times-row product, run element-wise add or multiply, clear the accumulators, or write the accumulators out to a result store (the odd bank). Results can be read back through a separate read port.

A matrix product is built as a sum of outer products. In each of K steps, one scalar from the loaded A column is broadcast to every lane and multiplied by a B row taken from the even bank. Each lane adds the product into its own running sum. Nothing is ever summed across lanes. The lane ALU has no subtract and no compare. Subtraction is done by first setting the operand register to minus one, then multiplying, then adding. Any opcode that would need a comparison (min/max) or is otherwise unassigned is refused.

Top module: `olpa_array`

## Requirements
- R1: After reset, every accumulator, operand register and result-store row is zero, and both `out_valid` and `illegal_op` are low.
- R2: Opcode 0 (load) copies even-bank row `op_addr` into the operand registers, lane i taking bits [16i+15:16i], and leaves the accumulators unchanged.
- R3: Opcode 1 (broadcast MAC) takes the operand-register value of lane `op_sel`. For each lane i, it forms the saturated Q8.8 product of that scalar and lane i of even-bank row `op_addr`, then saturating-adds it into accumulator i.
- R4: A series of K broadcast MACs leaves in each lane exactly the sum of its own K products; no lane's result depends on another lane's row data.
- R5: Opcode 2 (add) sets each accumulator to the saturating sum of itself and lane i of even-bank row `op_addr`.
- R6: Opcode 3 (multiply) overwrites each accumulator with the saturated Q8.8 product of operand lane i and lane i of even-bank row `op_addr`.
- R7: Opcode 6 (negate-vector) sets every operand lane to 0xFF00 (minus one in Q8.8). The sequence 6, 3 on row y, 2 on row x leaves x minus y in each accumulator.
- R8: Values are signed 16-bit Q8.8. A product is the full product shifted right arithmetically by 8. Sums and products outside [-32768, 32767] clamp to the nearer bound.
- R9: Opcode 5 (clear) zeroes every accumulator.
- R10: Opcode 4 (store) writes the accumulators to result-store row `op_addr`. In the next cycle it raises `out_valid` for exactly one cycle, with `out_data` equal to the stored accumulators. The row is then readable on `od_rdata` for `od_raddr`.
- R11: Opcode 7 (min/max, not supported) and opcodes 8 to 15 raise `illegal_op` for one cycle in the next cycle and change no accumulator, operand register or result-store row.
- R12: While `op_valid` is low, `op_code` is ignored: no state changes and neither `out_valid` nor `illegal_op` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_we | input | 1 | Even-bank write enable |
| ev_waddr | input | 3 | Even-bank write row |
| ev_wdata | input | 256 | Even-bank write data, lane i in bits [16i+15:16i] |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code |
| op_addr | input | 3 | Bank row used by the operation |
| op_sel | input | 4 | Lane whose operand is broadcast by a MAC |
| out_valid | output | 1 | One-cycle pulse after a store |
| out_data | output | 256 | Accumulators captured by the store |
| illegal_op | output | 1 | One-cycle pulse after a refused opcode |
| od_raddr | input | 3 | Result-store read row |
| od_rdata | output | 256 | Result-store read data |

## Verification
The properties assume that `op_code` and `op_valid` are stable across each rising edge, and that host writes to the even bank never need to be seen by an operation in the same cycle. The stimulus keeps to this by driving all inputs on the falling edge. It finishes loading the even bank before issuing any operation that reads it. The store property compares `out_data` against the accumulators one cycle earlier. This relies on the bench never issuing a store while reset is being released, and the bench only starts operations several cycles after reset.

// File: rtl/olpa_pkg.sv
package olpa_pkg;
    localparam int DW   = 16;
    localparam int FRAC = 8;

    localparam logic [3:0] OP_FILL = 4'd0;
    localparam logic [3:0] OP_MAC  = 4'd1;
    localparam logic [3:0] OP_ADD  = 4'd2;
    localparam logic [3:0] OP_MUL  = 4'd3;
    localparam logic [3:0] OP_MOV  = 4'd4;
    localparam logic [3:0] OP_CLR  = 4'd5;
    localparam logic [3:0] OP_NEGV = 4'd6;
    localparam logic [3:0] OP_LAST = OP_NEGV;

    localparam logic signed [DW-1:0] Q_MAX     = {1'b0, {(DW-1){1'b1}}};
    localparam logic signed [DW-1:0] Q_MIN     = {1'b1, {(DW-1){1'b0}}};
    localparam logic signed [DW-1:0] Q_NEG_ONE = -(DW'(1) << FRAC);

    typedef logic signed [DW-1:0] word_t;

    function automatic word_t sat_add(input word_t a, input word_t b);
        logic signed [DW:0] s;
        s = {a[DW-1], a} + {b[DW-1], b};
        if (s[DW] != s[DW-1]) return s[DW] ? Q_MIN : Q_MAX;
        return s[DW-1:0];
    endfunction

    function automatic word_t q_mul(input word_t a, input word_t b);
        logic signed [2*DW-1:0] p;
        logic signed [2*DW-1:0] sh;
        logic [DW:0] hi;
        p  = a * b;
        sh = p >>> FRAC;
        hi = sh[2*DW-1:DW-1];
        if ((&hi) || !(|hi)) return sh[DW-1:0];
        return sh[2*DW-1] ? Q_MIN : Q_MAX;
    endfunction
endpackage

// File: rtl/olpa_bank.sv
module olpa_bank #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 256,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_d [DEPTH];
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_comb begin
        for (int r = 0; r < DEPTH; r++) mem_d[r] = mem_q[r];
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk) begin
        for (int r = 0; r < DEPTH; r++) begin
            if (!rst_n) mem_q[r] <= '0;
            else        mem_q[r] <= mem_d[r];
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/olpa_lane.sv
module olpa_lane
    import olpa_pkg::*;
(
    input  logic        strobe,
    input  logic [3:0]  op,
    input  word_t       opr_q,
    input  word_t       acc_q,
    input  word_t       row_elem,
    input  word_t       bcast,
    output word_t       opr_d,
    output word_t       acc_d
);
    always_comb begin
        opr_d = opr_q;
        acc_d = acc_q;
        if (strobe) begin
            case (op)
                OP_FILL: opr_d = row_elem;
                OP_MAC:  acc_d = sat_add(acc_q, q_mul(bcast, row_elem));
                OP_ADD:  acc_d = sat_add(acc_q, row_elem);
                OP_MUL:  acc_d = q_mul(opr_q, row_elem);
                OP_CLR:  acc_d = '0;
                OP_NEGV: opr_d = Q_NEG_ONE;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/olpa_array.sv
module olpa_array
    import olpa_pkg::*;
#(
    parameter int LANES = 16,
    parameter int DEPTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int SW = $clog2(LANES),
    localparam int VW = LANES * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_we,
    input  logic [AW-1:0] ev_waddr,
    input  logic [VW-1:0] ev_wdata,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [AW-1:0] op_addr,
    input  logic [SW-1:0] op_sel,
    output logic          out_valid,
    output logic [VW-1:0] out_data,
    output logic          illegal_op,
    input  logic [AW-1:0] od_raddr,
    output logic [VW-1:0] od_rdata
);
    typedef struct packed {
        logic [LANES-1:0][DW-1:0] opr;
        logic [LANES-1:0][DW-1:0] acc;
        logic [LANES-1:0][DW-1:0] odat;
        logic                     ov;
        logic                     ill;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0][DW-1:0] row_q;
    logic [LANES-1:0][DW-1:0] opr_next;
    logic [LANES-1:0][DW-1:0] acc_next;
    logic [VW-1:0]            row_flat;
    logic                     legal;
    logic                     strobe;
    logic                     do_mov;
    word_t                    bcast;

    assign legal  = (op_code <= OP_LAST);
    assign strobe = op_valid && legal;
    assign do_mov = op_valid && (op_code == OP_MOV);
    assign bcast  = st_q.opr[op_sel];
    assign row_q  = row_flat;

    olpa_bank #(.DEPTH(DEPTH), .WIDTH(VW)) u_even (
        .clk(clk), .rst_n(rst_n), .we(ev_we), .waddr(ev_waddr),
        .wdata(ev_wdata), .raddr(op_addr), .rdata(row_flat)
    );

    olpa_bank #(.DEPTH(DEPTH), .WIDTH(VW)) u_odd (
        .clk(clk), .rst_n(rst_n), .we(do_mov), .waddr(op_addr),
        .wdata(st_q.acc), .raddr(od_raddr), .rdata(od_rdata)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        olpa_lane u_lane (
            .strobe   (strobe),
            .op       (op_code),
            .opr_q    (st_q.opr[i]),
            .acc_q    (st_q.acc[i]),
            .row_elem (row_q[i]),
            .bcast    (bcast),
            .opr_d    (opr_next[i]),
            .acc_d    (acc_next[i])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.opr  = opr_next;
        st_d.acc  = acc_next;
        st_d.ov   = do_mov;
        st_d.ill  = op_valid && !legal;
        if (do_mov) st_d.odat = st_q.acc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic [VW-1:0] acc_view;
    logic [VW-1:0] opr_view;
    assign acc_view   = st_q.acc;
    assign opr_view   = st_q.opr;
    assign out_valid  = st_q.ov;
    assign out_data   = st_q.odat;
    assign illegal_op = st_q.ill;
endmodule

// File: rtl/olpa_checker.sv
module olpa_checker #(
    parameter int VW = 256
) (
    input logic          clk,
    input logic          rst_n,
    input logic          op_valid,
    input logic [3:0]    op_code,
    input logic          out_valid,
    input logic [VW-1:0] out_data,
    input logic          illegal_op,
    input logic [VW-1:0] acc_view,
    input logic [VW-1:0] opr_view
);
    a_r11_flag_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd7) |=> illegal_op);

    a_r11_state_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code >= 4'd7) |=> ($stable(acc_view) && $stable(opr_view)));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_view) && $stable(opr_view) && !out_valid && !illegal_op));

    a_r9_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd5) |=> (acc_view == '0));

    a_r10_store_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd4) |=> (out_valid && out_data == $past(acc_view)));

    a_r10_no_stray_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_valid && op_code == 4'd4) |=> !out_valid);

    a_r2_fill_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_code == 4'd0) |=> $stable(acc_view));
endmodule

bind olpa_array olpa_checker #(.VW(VW)) u_chk (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .out_valid(out_valid), .out_data(out_data), .illegal_op(illegal_op),
    .acc_view(acc_view), .opr_view(opr_view)
);

// File: tb/test_olpa_array.sv
module test_olpa_array;
    localparam int L  = 16;
    localparam int D  = 8;
    localparam int VW = L * 16;

    logic clk = 0;
    logic rst_n = 0;
    logic ev_we = 0;
    logic [2:0] ev_waddr = '0;
    logic [VW-1:0] ev_wdata = '0;
    logic op_valid = 0;
    logic [3:0] op_code = '0;
    logic [2:0] op_addr = '0;
    logic [3:0] op_sel = '0;
    logic out_valid, illegal_op;
    logic [VW-1:0] out_data, od_rdata;
    logic [2:0] od_raddr = '0;

    always #10 clk = ~clk;

    olpa_array i_olpa_array (
        .clk(clk), .rst_n(rst_n), .ev_we(ev_we), .ev_waddr(ev_waddr),
        .ev_wdata(ev_wdata), .op_valid(op_valid), .op_code(op_code),
        .op_addr(op_addr), .op_sel(op_sel), .out_valid(out_valid),
        .out_data(out_data), .illegal_op(illegal_op),
        .od_raddr(od_raddr), .od_rdata(od_rdata)
    );

    typedef struct { bit mov; bit ill; logic [VW-1:0] data; string tag; } rec_t;
    rec_t q[$];

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int ev  [D][L];
    int odd [D][L];
    int opr [L];
    int acc [L];

    function automatic int clamp(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic int qm(input int a, input int b);
        int p;
        p = a * b;
        p = p >>> 8;
        return clamp(p);
    endfunction

    function automatic logic [VW-1:0] pack(input int v [L]);
        logic [VW-1:0] r;
        for (int i = 0; i < L; i++) r[i*16 +: 16] = 16'(v[i]);
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_row(input int r);
        int v [L];
        for (int i = 0; i < L; i++) v[i] = ev[r][i];
        @(negedge clk);
        ev_we = 1; ev_waddr = 3'(r); ev_wdata = pack(v);
        @(negedge clk);
        ev_we = 0;
    endtask

    task automatic issue(input logic [3:0] c, input int a, input int s, input string tag);
        rec_t rc;
        int b;
        @(negedge clk);
        op_valid = 1; op_code = c; op_addr = 3'(a); op_sel = 4'(s);
        case (c)
            4'd0: for (int i = 0; i < L; i++) opr[i] = ev[a][i];
            4'd1: begin
                b = opr[s];
                for (int i = 0; i < L; i++) acc[i] = clamp(acc[i] + qm(b, ev[a][i]));
            end
            4'd2: for (int i = 0; i < L; i++) acc[i] = clamp(acc[i] + ev[a][i]);
            4'd3: for (int i = 0; i < L; i++) acc[i] = qm(opr[i], ev[a][i]);
            4'd4: begin
                rc.mov = 1; rc.ill = 0; rc.data = pack(acc); rc.tag = tag;
                q.push_back(rc);
                for (int i = 0; i < L; i++) odd[a][i] = acc[i];
            end
            4'd5: for (int i = 0; i < L; i++) acc[i] = 0;
            4'd6: for (int i = 0; i < L; i++) opr[i] = -256;
            default: begin
                rc.mov = 0; rc.ill = 1; rc.data = '0; rc.tag = tag;
                q.push_back(rc);
            end
        endcase
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            op_valid = 0;
        end
    endtask

    task automatic chk_odd(input int a, input string tag);
        int v [L];
        for (int i = 0; i < L; i++) v[i] = odd[a][i];
        od_raddr = 3'(a);
        #1;
        check(od_rdata === pack(v), tag, od_rdata, pack(v));
    endtask

    // monitor: pops one expected item for every pulse the design produces
    always @(negedge clk) begin
        if (rst_n && !done && (out_valid || illegal_op)) begin
            if (q.size() == 0) begin
                check(0, "R10/R11 unexpected pulse", {out_valid, illegal_op}, '0);
            end else begin
                rec_t e;
                e = q.pop_front();
                check(out_valid === e.mov && illegal_op === e.ill &&
                      (!e.mov || out_data === e.data), e.tag, out_data, e.data);
            end
        end
    end

    task automatic finish_run;
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check(0, "watchdog expired", '0, '1);
        finish_run();
    end

    initial begin
        for (int r = 0; r < D; r++)
            for (int i = 0; i < L; i++) begin
                odd[r][i] = 0;
                if (r < 6) ev[r][i] = (((r * 29 + i * 17) % 97) - 48) * 24;
                else if (r == 6) ev[r][i] = 28672;
                else ev[r][i] = (i % 2 == 0) ? 32767 : -32768;
            end
        for (int i = 0; i < L; i++) begin opr[i] = 0; acc[i] = 0; end

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(out_valid === 1'b0 && illegal_op === 1'b0, "R1 flags after reset",
              {out_valid, illegal_op}, '0);
        chk_odd(3, "R1 result store cleared");
        issue(4'd4, 0, 0, "R1 accumulators zero");
        idle(2);

        for (int r = 0; r < D; r++) wr_row(r);

        // R3 R4: outer product over K=4 steps
        issue(4'd5, 0, 0, "R9");
        issue(4'd0, 0, 0, "R2");
        for (int k = 0; k < 4; k++) issue(4'd1, k + 1, k * 3, "R3");
        issue(4'd4, 1, 0, "R4 K-step outer product");
        idle(2);
        chk_odd(1, "R4 stored product row");

        // R5: element-wise add
        issue(4'd5, 0, 0, "R9");
        issue(4'd2, 2, 0, "R5");
        issue(4'd2, 3, 0, "R5");
        issue(4'd4, 2, 0, "R5 add result");
        // R6 R2: element-wise multiply after a load
        issue(4'd0, 4, 0, "R2");
        issue(4'd3, 5, 0, "R6");
        issue(4'd4, 3, 0, "R6 multiply result (R2 load)");
        // R7: subtraction via negate, multiply, add
        issue(4'd6, 0, 0, "R7");
        issue(4'd3, 2, 0, "R7");
        issue(4'd2, 3, 0, "R7");
        issue(4'd4, 4, 0, "R7 subtract result");
        // R8: saturation of sums and products
        issue(4'd5, 0, 0, "R9");
        issue(4'd2, 6, 0, "R8");
        issue(4'd2, 6, 0, "R8");
        issue(4'd4, 5, 0, "R8 saturated sum");
        issue(4'd0, 6, 0, "R2");
        issue(4'd3, 6, 0, "R8");
        issue(4'd4, 6, 0, "R8 saturated product");
        issue(4'd6, 0, 0, "R7");
        issue(4'd3, 7, 0, "R8");
        issue(4'd4, 7, 0, "R8 negated extremes");
        issue(4'd1, 7, 5, "R8");
        issue(4'd4, 0, 0, "R8 saturated MAC");
        idle(2);

        // R11: refused opcodes keep state
        issue(4'd0, 1, 0, "R2");
        issue(4'd7, 2, 0, "R11 min/max refused");
        issue(4'd9, 3, 0, "R11 opcode 9 refused");
        issue(4'd15, 4, 0, "R11 opcode 15 refused");
        issue(4'd4, 2, 0, "R11 accumulators kept");
        issue(4'd3, 3, 0, "R11");
        issue(4'd4, 3, 0, "R11 operand kept");
        // R12: ignored opcode while strobe low
        @(negedge clk);
        op_valid = 0; op_code = 4'd5;
        @(negedge clk);
        op_code = 4'd7;
        @(negedge clk);
        op_code = 4'd4; op_addr = 3'd5;
        issue(4'd4, 6, 0, "R12 idle opcode ignored");
        idle(3);

        for (int r = 0; r < D; r++) chk_odd(r, "R10 result store contents");
        check(q.size() == 0, "R10/R11 missing pulse", 256'(q.size()), '0);
        finish_run();
    end
endmodule